// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits next to a cache and keeps a short first-in first-out queue of block addresses that were fetched ahead of a sequential miss stream. Prefetched blocks stay in the queue and do not reach the cache until the cache actually asks for them. When the cache misses, it presents the missing block address as a lookup. Only the oldest entry is compared with that address. If the oldest entry matches and its data has returned, the block is handed to the cache, the queue advances by one, and the freed slot is refilled with the next sequential block. Any other outcome flushes the queue and restarts the stream after the missed block. The missed block itself is served by the normal demand path.

Prefetch requests go to memory over a valid/ready handshake. Each request carries the block address and a generation number. The generation number changes on every flush. Returning fills quote both the address and the generation, so data that comes back for a flushed stream is dropped. Only addresses and status bits are modelled. No data payload is stored.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset the queue is empty, the stream is inactive, `pf_valid` and `rsp_valid` are 0, and the generation number is 0.
- R2: A lookup that misses is accepted in the same cycle (`lk_ready`=1). In the next cycle `rsp_valid`=1, `rsp_hit`=0 and `rsp_addr` equals the looked-up address. A lookup misses when the queue is empty or the oldest entry has a different address. The miss discards every queued entry.
- R3: After a miss on block A, prefetches are offered for A+1, A+2, and so on in increasing order. `pf_addr` and `pf_gen` hold steady while `pf_ready` is 0. The offered address advances by exactly one block only on a cycle with `pf_valid`=1 and `pf_ready`=1.
- R4: At most DEPTH blocks are queued. With DEPTH entries held, `pf_valid` is 0 regardless of `pf_ready`.
- R5: A lookup that matches the oldest entry after that entry's fill has returned is accepted in the same cycle. In the next cycle `rsp_valid`=1, `rsp_hit`=1 and `rsp_addr` equals the block address.
- R6: A head hit removes the oldest entry and advances the rest by one place. The freed slot is then offered to memory as the block after the last one requested, with no restart of the stream.
- R7: A lookup that matches the oldest entry before its fill has returned is held with `lk_ready`=0 and produces no response. It does not flush. The cycle after the matching fill is taken, the lookup is accepted as a hit.
- R8: A lookup that matches a queued entry other than the oldest is treated as a miss. The stream restarts after that address.
- R9: A fill marks an entry as returned only when both its address and its generation equal those of a queued entry. A fill quoting a generation from before a flush has no effect.
- R10: Every miss increments the generation by one, modulo 2^GEN_W. `pf_gen` carries the current generation on every prefetch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Cache-miss lookup present |
| lk_addr | input | ADDR_W | Block address of the lookup |
| lk_ready | output | 1 | Lookup accepted this cycle (low while stalled) |
| rsp_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| rsp_hit | output | 1 | 1 when the block was supplied from the queue head |
| rsp_addr | output | ADDR_W | Block address of the answered lookup |
| pf_valid | output | 1 | Prefetch request offered to memory |
| pf_ready | input | 1 | Memory takes the offered request |
| pf_addr | output | ADDR_W | Block address to prefetch |
| pf_gen | output | GEN_W | Generation number of the request |
| fill_valid | input | 1 | Memory returns a prefetched block |
| fill_addr | input | ADDR_W | Block address of the returned fill |
| fill_gen | input | GEN_W | Generation number quoted by the fill |

## Verification
The bench targets the cases that separate a head-only stream buffer from a general lookaside queue.

- A lookup that matches the second entry must flush and restart. A design that searched the whole queue would answer it as a hit.
- A lookup on a head whose data is still outstanding must stall without flushing. A design that got this wrong would emit a miss response and move the prefetch address.
- A fill that quotes the generation before a flush, for an address that is queued again, must leave the head unreturned. A design that ignored the generation would hit early.
- Memory back-pressure and a full queue are exercised so that a design that advances or overfills without the handshake shows a wrong `pf_addr` or a spurious `pf_valid`.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Outcome of comparing a lookup against the queue head
    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_HIT  = 2'd1,
        LK_WAIT = 2'd2,
        LK_MISS = 2'd3
    } lk_kind_e;

endpackage

// File: rtl/sb_lookup.sv
module sb_lookup
    import sb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              head_vld,
    input  logic              head_avail,
    input  logic [ADDR_W-1:0] head_addr,
    output lk_kind_e          kind
);

    logic head_match;

    always_comb begin
        head_match = head_vld && (head_addr == lk_addr);
        kind       = LK_NONE;
        if (lk_valid) begin
            if (head_match) begin
                kind = head_avail ? LK_HIT : LK_WAIT;
            end else begin
                kind = LK_MISS;
            end
        end
    end

endmodule

// File: rtl/sb_issue.sv
module sb_issue #(
    parameter int ADDR_W = 32,
    parameter int GEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              fire,
    output logic              active,
    output logic [ADDR_W-1:0] next_addr,
    output logic [GEN_W-1:0]  gen
);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [GEN_W-1:0]  gen;
    } iss_state_t;

    iss_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.active = 1'b1;
            st_d.addr   = flush_addr + ADDR_W'(1);
            st_d.gen    = st_q.gen + GEN_W'(1);
        end else if (fire) begin
            st_d.addr   = st_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.active;
    assign next_addr = st_q.addr;
    assign gen       = st_q.gen;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !flush) |=> (next_addr == $past(next_addr) + ADDR_W'(1))); // R3
    AST_RESTART_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (next_addr == $past(flush_addr) + ADDR_W'(1)));           // R3
    AST_GEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (gen == $past(gen) + GEN_W'(1)));                         // R10
    AST_GEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> $stable(gen));                                           // R10

endmodule

// File: rtl/sb_queue.sv
module sb_queue #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    parameter int GEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [GEN_W-1:0]  push_gen,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [GEN_W-1:0]  fill_gen,
    input  logic              pop,
    input  logic              flush,
    output logic              head_vld,
    output logic              head_avail,
    output logic [ADDR_W-1:0] head_addr,
    output logic              full
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              vld;
        logic              avail;
        logic [GEN_W-1:0]  gen;
        logic [ADDR_W-1:0] addr;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0] cnt;
    } q_state_t;

    q_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // append the newly issued request at the tail
        for (int i = 0; i < DEPTH; i++) begin
            if (push && (st_q.cnt == CNT_W'(i))) begin
                st_d.ent[i].vld   = 1'b1;
                st_d.ent[i].avail = 1'b0;
                st_d.ent[i].gen   = push_gen;
                st_d.ent[i].addr  = push_addr;
            end
        end
        // returned data marks a matching entry of the same generation
        for (int i = 0; i < DEPTH; i++) begin
            if (fill_valid && st_q.ent[i].vld &&
                (st_q.ent[i].gen == fill_gen) &&
                (st_q.ent[i].addr == fill_addr)) begin
                st_d.ent[i].avail = 1'b1;
            end
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
        // head leaves toward the cache, the rest advance
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.ent[i] = st_d.ent[i+1];
            end
            st_d.ent[DEPTH-1] = '0;
        end
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_vld   = st_q.ent[0].vld;
    assign head_avail = st_q.ent[0].avail;
    assign head_addr  = st_q.ent[0].addr;
    assign full       = (st_q.cnt == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);                                            // R4
    AST_POP_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (head_vld && head_avail));                          // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!head_vld && st_q.cnt == '0));                   // R2
    AST_POP_NOT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && flush));                                           // R8

endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
    import sb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    parameter int GEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [GEN_W-1:0]  pf_gen,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [GEN_W-1:0]  fill_gen
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    lk_kind_e          kind;
    logic              head_vld, head_avail, full;
    logic [ADDR_W-1:0] head_addr;
    logic              is_hit, is_miss, fire, active;
    rsp_t              rsp_d, rsp_q;

    sb_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .head_vld   (head_vld),
        .head_avail (head_avail),
        .head_addr  (head_addr),
        .kind       (kind)
    );

    assign is_hit   = (kind == LK_HIT);
    assign is_miss  = (kind == LK_MISS);
    assign lk_ready = is_hit || is_miss;
    assign pf_valid = active && !full;
    assign fire     = pf_valid && pf_ready;

    sb_issue #(.ADDR_W(ADDR_W), .GEN_W(GEN_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (is_miss),
        .flush_addr (lk_addr),
        .fire       (fire),
        .active     (active),
        .next_addr  (pf_addr),
        .gen        (pf_gen)
    );

    sb_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .GEN_W(GEN_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (fire),
        .push_addr  (pf_addr),
        .push_gen   (pf_gen),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_gen   (fill_gen),
        .pop        (is_hit),
        .flush      (is_miss),
        .head_vld   (head_vld),
        .head_avail (head_avail),
        .head_addr  (head_addr),
        .full       (full)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_ready;
        rsp_d.hit   = is_hit;
        rsp_d.addr  = lk_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_addr  = rsp_q.addr;

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid);                                  // R5
    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ready) |=> !rsp_valid);                                // R7
    AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !is_miss) |=>
            (pf_valid && $stable(pf_addr) && $stable(pf_gen)));                 // R3
    AST_HIT_NEEDS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> active);                                     // R5

endmodule

// File: tb/tb_stream_prefetch_buf.sv
module tb_stream_prefetch_buf;

    localparam int AW = 32;
    localparam int GW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_ready;
    logic          rsp_valid, rsp_hit;
    logic [AW-1:0] rsp_addr;
    logic          pf_valid;
    logic          pf_ready = 1'b0;
    logic [AW-1:0] pf_addr;
    logic [GW-1:0] pf_gen;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [GW-1:0] fill_gen = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic          hit;
        logic [AW-1:0] addr;
        string         req;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    stream_prefetch_buf #(.ADDR_W(AW), .DEPTH(4), .GEN_W(GW)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_gen(pf_gen),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_gen(fill_gen)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a response appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk("R7", "unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, "rsp_hit", 64'(rsp_hit), 64'(e.hit));
                chk(e.req, "rsp_addr", 64'(rsp_addr), 64'(e.addr));
            end
        end
    end

    task automatic push_exp(input logic hit, input logic [AW-1:0] a, input string req);
        exp_t e;
        e.hit = hit; e.addr = a; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic exp_hit, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        #1;
        chk(req, "lk_ready", 64'(lk_ready), 64'd1);
        push_exp(exp_hit, a, req);
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [GW-1:0] g, input string req);
        @(negedge clk);
        pf_ready = 1'b1;
        #1;
        chk(req, "pf_valid", 64'(pf_valid), 64'd1);
        chk(req, "pf_addr", 64'(pf_addr), 64'(a));
        chk("R10", "pf_gen", 64'(pf_gen), 64'(g));
        @(posedge clk); #1;
        pf_ready = 1'b0;
    endtask

    task automatic fill(input logic [AW-1:0] a, input logic [GW-1:0] g);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_gen = g;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pf_valid after reset", 64'(pf_valid), 64'd0);
        chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1", "pf_gen after reset", 64'(pf_gen), 64'd0);

        // empty buffer: miss, stream starts after 100 in generation 1
        lookup(32'd100, 1'b0, "R2");
        // back-pressure holds the offer
        repeat (2) begin
            @(negedge clk);
            chk("R3", "pf_valid under back-pressure", 64'(pf_valid), 64'd1);
            chk("R3", "pf_addr held", 64'(pf_addr), 64'd101);
        end
        for (int i = 1; i <= 4; i++) issue(32'(100 + i), 3'd1, "R3");
        @(negedge clk);
        pf_ready = 1'b1;
        #1 chk("R4", "pf_valid with queue full", 64'(pf_valid), 64'd0);
        @(posedge clk); #1 pf_ready = 1'b0;

        // head returned then hit
        fill(32'd101, 3'd1);
        lookup(32'd101, 1'b1, "R5");
        issue(32'd105, 3'd1, "R6");

        // head not yet returned: stall, no flush
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'd102;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R7", "lk_ready while head pending", 64'(lk_ready), 64'd0);
            @(negedge clk);
        end
        fill_valid = 1'b1; fill_addr = 32'd102; fill_gen = 3'd1;
        #1 chk("R7", "lk_ready in fill cycle", 64'(lk_ready), 64'd0);
        @(posedge clk); #1 fill_valid = 1'b0;
        @(negedge clk);
        #1 chk("R7", "lk_ready after fill", 64'(lk_ready), 64'd1);
        push_exp(1'b1, 32'd102, "R7");
        @(posedge clk); #1 lk_valid = 1'b0;
        issue(32'd106, 3'd1, "R7");

        // non-head match: queue is 103..106; 104 must miss and restart at 105
        fill(32'd103, 3'd1);
        lookup(32'd104, 1'b0, "R8");
        issue(32'd105, 3'd2, "R8");
        for (int i = 6; i <= 8; i++) issue(32'(100 + i), 3'd2, "R3");

        // stale generation fill for a requeued address is ignored
        fill(32'd105, 3'd1);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'd105;
        #1 chk("R9", "lk_ready after stale fill", 64'(lk_ready), 64'd0);
        @(posedge clk); #1 lk_valid = 1'b0;
        fill(32'd105, 3'd2);
        lookup(32'd105, 1'b1, "R9");
        issue(32'd109, 3'd2, "R6");

        // successive misses advance the generation
        lookup(32'd500, 1'b0, "R10");
        lookup(32'd600, 1'b0, "R10");
        @(negedge clk);
        chk("R10", "pf_gen after two misses", 64'(pf_gen), 64'd4);
        chk("R3", "pf_addr after restart", 64'(pf_addr), 64'd601);

        repeat (2) @(negedge clk);
        chk("R2", "scoreboard drained", 64'(sb_q.size()), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule